// File: doc/BRIEF.md
# Memory Self-Test Control Register

This block is a single 16-bit control and status register on a simple CPU register bus. It runs built-in self-test on three on-chip memories: the backplane data store, the local data store and the backplane connection store. Each memory has a test engine and a small parameterised RAM model. The engine runs a March C- sequence over its RAM and records whether every read returned the value it expected.

Software arms the block by writing the test-mode enable on its own. It then launches tests by raising one or more start bits while test mode stays on. Software polls the per-memory completion flags and reads each pass flag once its completion flag is set. Any write that clears test mode disarms the block and aborts every test. A stuck-at fault can be forced onto one bit of one RAM through dedicated inputs, so that the fail path can be exercised.

Top module: `mst_ctrl`

## Requirements
- R1: After reset, every bit of the register reads 0.
- R2: Only bus address 0x014D is decoded. A write to any other address changes nothing, and a read of any other address returns 0. Read data appears on `reg_rdata` in the cycle after the cycle in which `reg_rd` is sampled.
- R3: Bits 15:13 and 2:0 always read 0, and writes to them have no effect.
- R4: Bit 12 is the test-mode enable. It reads back the value last written.
- R5: A start request counts only if bit 12 was already 1 before the write that carries it. Otherwise the start bits of that write are discarded and read back 0, and no test runs.
- R6: Start bits are at 11 (backplane data), 8 (local data) and 5 (backplane connection). A test begins only when a start bit goes from 0 to 1. Writing a start bit that is already 1 does not restart that test.
- R7: The completion flags are at bits 10, 7 and 4, in the same memory order. Each goes to 1 when its memory's sequence ends and stays at 1 until a restart or an abort.
- R8: The pass flags are at bits 9, 6 and 3, in the same memory order. A pass flag is 1 only while its completion flag is 1. It reads 1 on a fault-free memory.
- R9: A restart clears that memory's completion and pass flags, starting with the first read after the start write. The flags of the other memories are left unchanged.
- R10: A write with bit 12 at 0 aborts every running test and clears all start, completion and pass flags.
- R11: A stuck-at-0 or stuck-at-1 fault forced on any bit and address of one RAM makes that memory finish with pass 0. The other memories still pass.
- R12: Several start bits raised in the same write launch independent tests that run at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | BUS_AW | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| flt_en | input | 1 | Enable forced stuck-at fault |
| flt_mem | input | 2 | Target memory (0 backplane data, 1 local data, 2 backplane connection) |
| flt_addr | input | AW | Faulty word address |
| flt_bit | input | $clog2(DW) | Faulty bit index |
| flt_val | input | 1 | Stuck value |

## Verification
Assertions check on every cycle that each engine keeps its completion and pass flags consistent. A pass flag never stands without its completion flag, an abort or a restart clears both flags, and an idle result holds steady. Other assertions check that no start pulse leaves the arming logic unless the block was armed, and that a start bit written at the same level never produces a pulse. Some behaviour can only be shown by the bench's scenarios: that the march sequence really catches every stuck-at bit at swept addresses, bit positions and polarities, that unfaulted memories still pass, and that the register layout, arming order and abort effects are visible through bus reads.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned NUM_MEM = 3;
  localparam int unsigned TM_POS  = 12;

  function automatic int unsigned start_pos(input int unsigned idx);
    return 11 - 3 * idx;
  endfunction

  function automatic int unsigned done_pos(input int unsigned idx);
    return 10 - 3 * idx;
  endfunction

  function automatic int unsigned pass_pos(input int unsigned idx);
    return 9 - 3 * idx;
  endfunction

  typedef enum logic [2:0] {
    EL_W0   = 3'd0,
    EL_R0W1 = 3'd1,
    EL_R1W0 = 3'd2,
    EL_D0W1 = 3'd3,
    EL_D1W0 = 3'd4,
    EL_R0   = 3'd5
  } march_el_e;
endpackage

// File: rtl/mst_ram.sv
module mst_ram #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 4,
  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd,
  input  logic          flt_en,
  input  logic [AW-1:0] flt_addr,
  input  logic [BW-1:0] flt_bit,
  input  logic          flt_val
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] flt_mask;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd_q      <= mem[addr];
    rd_addr_q <= addr;
  end

  always_comb begin
    flt_mask = '0;
    if (flt_en && (rd_addr_q == flt_addr)) flt_mask[flt_bit] = 1'b1;
  end

  assign rd = (rd_q & ~flt_mask) | (flt_val ? flt_mask : '0);
endmodule

// File: rtl/mst_march.sv
module mst_march
  import mst_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 4,
  localparam logic [AW-1:0] MAXA = {AW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wd,
  input  logic [DW-1:0] ram_rd,
  output logic          done_o,
  output logic          pass_o
);
  march_el_e     el_q;
  logic          run_q, ph_q, fail_q;
  logic [AW-1:0] addr_q;
  logic          desc, last, exp_one, wr_one, mis, fail_n;

  always_comb begin
    desc    = (el_q == EL_D0W1) || (el_q == EL_D1W0);
    last    = desc ? (addr_q == '0) : (addr_q == MAXA);
    exp_one = (el_q == EL_R1W0) || (el_q == EL_D1W0);
    wr_one  = (el_q == EL_R0W1) || (el_q == EL_D0W1);
    mis     = ram_rd != (exp_one ? {DW{1'b1}} : {DW{1'b0}});
    fail_n  = fail_q | mis;
    ram_addr = addr_q;
    ram_we   = run_q && ((el_q == EL_W0) || (ph_q && el_q != EL_R0));
    ram_wd   = wr_one ? {DW{1'b1}} : {DW{1'b0}};
  end

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      run_q <= 1'b0; ph_q <= 1'b0; fail_q <= 1'b0;
      done_o <= 1'b0; pass_o <= 1'b0;
      el_q <= EL_W0; addr_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1; ph_q <= 1'b0; fail_q <= 1'b0;
      done_o <= 1'b0; pass_o <= 1'b0;
      el_q <= EL_W0; addr_q <= '0;
    end else if (run_q) begin
      if (el_q == EL_W0) begin
        if (last) begin
          el_q <= EL_R0W1; addr_q <= '0;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end else if (!ph_q) begin
        ph_q <= 1'b1;
      end else begin
        ph_q   <= 1'b0;
        fail_q <= fail_n;
        if (last) begin
          case (el_q)
            EL_R0W1: begin el_q <= EL_R1W0; addr_q <= '0;   end
            EL_R1W0: begin el_q <= EL_D0W1; addr_q <= MAXA; end
            EL_D0W1: begin el_q <= EL_D1W0; addr_q <= MAXA; end
            EL_D1W0: begin el_q <= EL_R0;   addr_q <= '0;   end
            default: begin
              run_q  <= 1'b0;
              done_o <= 1'b1;
              pass_o <= ~fail_n;
            end
          endcase
        end else begin
          addr_q <= desc ? addr_q - 1'b1 : addr_q + 1'b1;
        end
      end
    end
  end

  a_r8_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!done_o && !pass_o));
  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start_i && !abort_i) |=> (!done_o && !pass_o));
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i && !abort_i) |=> (done_o && $stable(pass_o)));
endmodule

// File: rtl/mst_arm.sv
module mst_arm
  import mst_pkg::*;
#(
  parameter int unsigned NM = NUM_MEM
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic          wr_tm,
  input  logic [NM-1:0] wr_start,
  output logic          tm_o,
  output logic [NM-1:0] st_o,
  output logic [NM-1:0] start_p,
  output logic          abort_p
);
  logic          tm_q;
  logic [NM-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q <= 1'b0;
      st_q <= '0;
    end else if (wr_hit) begin
      tm_q <= wr_tm;
      st_q <= (wr_tm && tm_q) ? wr_start : '0;
    end
  end

  assign start_p = (wr_hit && wr_tm && tm_q) ? (wr_start & ~st_q) : '0;
  assign abort_p = wr_hit && !wr_tm;
  assign tm_o    = tm_q;
  assign st_o    = st_q;

  for (genvar i = 0; i < NM; i++) begin : g_chk
    a_r5_no_start_unarmed: assert property (@(posedge clk) disable iff (rst)
      start_p[i] |-> tm_q);
    a_r6_level_no_restart: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && st_q[i]) |-> !start_p[i]);
  end
endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
  import mst_pkg::*;
#(
  parameter int unsigned BUS_AW   = 16,
  parameter logic [BUS_AW-1:0] REG_ADDR = 16'h014D,
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 4,
  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              flt_en,
  input  logic [1:0]        flt_mem,
  input  logic [AW-1:0]     flt_addr,
  input  logic [BW-1:0]     flt_bit,
  input  logic              flt_val
);
  logic               hit, wr_hit, tm;
  logic [NUM_MEM-1:0] wr_start, st, start_p, done, pass;
  logic               abort_p;
  logic [REG_W-1:0]   view;

  assign hit    = (reg_addr == REG_ADDR);
  assign wr_hit = reg_wr && hit;

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] wd, rd;

    assign wr_start[i] = reg_wdata[start_pos(i)];

    mst_march #(.AW(AW), .DW(DW)) u_eng (
      .clk(clk), .rst(rst), .start_i(start_p[i]), .abort_i(abort_p),
      .ram_we(we), .ram_addr(a), .ram_wd(wd), .ram_rd(rd),
      .done_o(done[i]), .pass_o(pass[i])
    );

    mst_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk(clk), .we(we), .addr(a), .wd(wd), .rd(rd),
      .flt_en(flt_en && (flt_mem == 2'(i))), .flt_addr(flt_addr),
      .flt_bit(flt_bit), .flt_val(flt_val)
    );
  end

  mst_arm #(.NM(NUM_MEM)) u_arm (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_tm(reg_wdata[TM_POS]),
    .wr_start(wr_start), .tm_o(tm), .st_o(st), .start_p(start_p),
    .abort_p(abort_p)
  );

  always_comb begin
    view = '0;
    view[TM_POS] = tm;
    for (int i = 0; i < NUM_MEM; i++) begin
      view[start_pos(i)] = st[i];
      view[done_pos(i)]  = done[i];
      view[pass_pos(i)]  = pass[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= (reg_rd && hit) ? view : '0;
  end

  a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !hit) |=> (reg_rdata == '0));
endmodule

// File: tb/mst_ctrl_bench.sv
module mst_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 4;

  logic        clk = 0, rst = 1;
  logic [15:0] reg_addr = 16'h014D, reg_wdata = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_rdata;
  logic        flt_en = 0, flt_val = 0;
  logic [1:0]  flt_mem = 0;
  logic [AW-1:0] flt_addr = 0;
  logic [1:0]  flt_bit = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mst_ctrl #(.AW(AW), .DW(DW)) u_mst_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .flt_en(flt_en), .flt_mem(flt_mem), .flt_addr(flt_addr),
    .flt_bit(flt_bit), .flt_val(flt_val)
  );

  function automatic logic [15:0] ew(bit tm, bit [2:0] s, bit [2:0] d, bit [2:0] p);
    logic [15:0] w = '0;
    w[12] = tm;
    for (int i = 0; i < 3; i++) begin
      w[11-3*i] = s[i]; w[10-3*i] = d[i]; w[9-3*i] = p[i];
    end
    return w;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_addr = 16'h014D;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata; reg_addr = 16'h014D;
  endtask

  task automatic poll(logic [15:0] mask, output logic [15:0] d);
    for (int k = 0; k < 600; k++) begin
      rd(16'h014D, d);
      if ((d & mask) == mask) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    rd(16'h014D, d); chk("R1 reset", d, 16'h0000);

    wr(16'h014C, 16'hFFFF);
    rd(16'h014D, d); chk("R2 other addr write", d, 16'h0000);
    wr(16'h014D, 16'h1000);
    rd(16'h014C, d); chk("R2 other addr read", d, 16'h0000);
    rd(16'h014D, d); chk("R4 test mode", d, 16'h1000);
    wr(16'h014D, 16'hF007);
    rd(16'h014D, d); chk("R3 reserved", d, 16'h1000);

    wr(16'h014D, 16'h0000);
    wr(16'h014D, ew(1, 3'b111, 0, 0));
    rd(16'h014D, d); chk("R5 unarmed start discarded", d, 16'h1000);
    repeat (200) @(negedge clk);
    rd(16'h014D, d); chk("R5 no test ran", d, 16'h1000);

    for (int m = 1; m < 8; m++) begin
      wr(16'h014D, 16'h0000);
      wr(16'h014D, 16'h1000);
      wr(16'h014D, ew(1, 3'(m), 0, 0));
      rd(16'h014D, d); chk("R12 started", d, ew(1, 3'(m), 0, 0));
      poll(ew(0, 0, 3'(m), 0), d);
      chk("R7 R8 R12 done and pass", d, ew(1, 3'(m), 3'(m), 3'(m)));
    end

    wr(16'h014D, ew(1, 3'b111, 0, 0));
    repeat (5) @(negedge clk);
    rd(16'h014D, d); chk("R6 level no restart", d, ew(1, 3'b111, 3'b111, 3'b111));
    wr(16'h014D, 16'h1000);
    wr(16'h014D, ew(1, 3'b001, 0, 0));
    rd(16'h014D, d); chk("R9 restart clears one", d, ew(1, 3'b001, 3'b110, 3'b110));
    poll(ew(0, 0, 3'b111, 0), d);
    chk("R6 R9 restart completes", d, ew(1, 3'b001, 3'b111, 3'b111));

    wr(16'h014D, 16'h0000);
    wr(16'h014D, 16'h1000);
    wr(16'h014D, ew(1, 3'b111, 0, 0));
    repeat (10) @(negedge clk);
    wr(16'h014D, 16'h0000);
    rd(16'h014D, d); chk("R10 abort", d, 16'h0000);
    repeat (150) @(negedge clk);
    rd(16'h014D, d); chk("R10 stays aborted", d, 16'h0000);

    flt_en = 1;
    for (int m = 0; m < 3; m++)
      for (int ai = 0; ai < 3; ai++)
        for (int b = 0; b < 4; b += 3)
          for (int v = 0; v < 2; v++) begin
            flt_mem = 2'(m);
            flt_addr = (ai == 0) ? 3'd0 : (ai == 1) ? 3'd5 : 3'd7;
            flt_bit = 2'(b);
            flt_val = v[0];
            wr(16'h014D, 16'h0000);
            wr(16'h014D, 16'h1000);
            wr(16'h014D, ew(1, 3'b111, 0, 0));
            poll(ew(0, 0, 3'b111, 0), d);
            chk("R11 stuck-at fault", d,
                ew(1, 3'b111, 3'b111, 3'b111 & ~(3'b001 << m)));
          end
    flt_en = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule